// File: doc/BRIEF.md
# Supply-Fault and Watchdog Reset Sequencer

This block turns three reset causes into one core reset for a small controller. The causes are a low-supply comparator, a deeper brown-out comparator and a watchdog expiry request. The two comparator flags come from the analog side and are resynchronized inside the block. The low-supply monitor is on by default. A firmware disable level can mask it, and so can the suspend indication. The brown-out monitor cannot be masked. A brown-out event re-arms the low-supply monitor until firmware gives the disable again.

A supply fault holds the core in reset for as long as the fault lasts. Once it clears, a settle counter runs before the core is released. The entry into a supply-fault reset also gives a one-cycle strobe that tells the clock logic to fall back to the internal oscillator. A watchdog request holds reset for a short fixed time only. It gives no settle period and no clock strobe. Two sticky cause flags let firmware find out why it restarted. The core reset drives everything downstream: interrupt masks, both stack pointers and the program counter return to zero while it is high. A single-cycle pulse marks the first cycle of execution.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `rst` is high, `core_rst_o` is 1, and the cause flags, `osc_int_force_o` and `run_start_o` are 0. With no fault present, `core_rst_o` falls STAB_CYCLES+1 clock edges after `rst` is released.
- R2: Each comparator input passes through SYNC_STAGES (2) flops. A rise on an enabled fault input sets `core_rst_o` and `cause_supply_o` 3 edges later when starting from run. At that same edge `osc_int_force_o` is 1 for exactly one cycle.
- R3: When every active fault has gone, `core_rst_o` falls SYNC_STAGES+1+STAB_CYCLES edges after the input drops. `run_start_o` is 1 only in the first cycle with `core_rst_o` low.
- R4: A fault that returns during the settle count sends the block back to hold. A later release then needs the full settle count again.
- R5: With `lv_off_i`=1 and no re-arm pending, `lv_low_i` has no effect on `core_rst_o` or the flags.
- R6: While `suspend_i`=1, `lv_low_i` is ignored. If the fault is still present, it causes a reset one edge after `suspend_i` falls.
- R7: `bo_low_i` resets the core whatever the values of `lv_off_i` and `suspend_i`.
- R8: A brown-out re-arms the low-supply monitor despite `lv_off_i`=1. The reset then holds while `lv_low_i` stays high, and the re-arm lasts until a rising edge of `lv_off_i`.
- R9: In run, a `wdog_req_i` of 1 raises `core_rst_o` and `cause_wdog_o` at the next edge. Reset is held for WD_CYCLES edges with no oscillator strobe. The request is ignored when reset is already held.
- R10: The cause flags survive every later core reset. `cause_clr_i` clears them at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst | input | 1 | Synchronous active-high power-on reset of the sequencer |
| lv_low_i | input | 1 | Raw flag: supply below the low-voltage threshold |
| bo_low_i | input | 1 | Raw flag: supply below the brown-out trip |
| lv_off_i | input | 1 | Firmware level disabling the low-voltage monitor |
| suspend_i | input | 1 | Device is in suspend |
| wdog_req_i | input | 1 | Watchdog expiry request, synchronous |
| cause_clr_i | input | 1 | Firmware strobe clearing both cause flags |
| core_rst_o | output | 1 | Core reset, active high |
| run_start_o | output | 1 | One-cycle pulse at the first cycle of execution |
| osc_int_force_o | output | 1 | One-cycle strobe forcing internal oscillator mode |
| cause_supply_o | output | 1 | Sticky flag: supply-fault reset occurred |
| cause_wdog_o | output | 1 | Sticky flag: watchdog reset occurred |

## Verification
Comparator results are due three edges after a raw change: two synchronizer flops plus the state register. Watchdog results are due one edge after the request, and a clear takes effect one edge after the strobe. A release is due SYNC_STAGES+1+STAB_CYCLES edges after the last fault drops, or WD_CYCLES+1 edges after a watchdog request. Every stimulus is applied 1 ns after a rising edge, and each vector holds its own edge count worked out from these latencies. Outputs are sampled at that same offset after the counted edge. Release checks sample one edge before the due edge and again on it, so an off-by-one count shows up.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_WDOG   = 2'd2,
    SEQ_RUN    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else if (g == 0) stage_q[g] <= async_i;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_fault_eval.sv
module pwr_fault_eval (
  input  logic clk,
  input  logic rst,
  input  logic lv_s,
  input  logic bo_s,
  input  logic lv_off,
  input  logic suspend,
  output logic supply_fault
);
  logic rearm_q;
  logic lv_off_q;
  logic lv_watch;

  always_ff @(posedge clk) begin
    if (rst) begin
      rearm_q  <= 1'b0;
      lv_off_q <= 1'b0;
    end else begin
      lv_off_q <= lv_off;
      if (bo_s) rearm_q <= 1'b1;
      else if (lv_off && !lv_off_q) rearm_q <= 1'b0;
    end
  end

  assign lv_watch     = (!lv_off || rearm_q) && !suspend;
  assign supply_fault = bo_s || (lv_s && lv_watch);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_rst_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter int WD_CYCLES   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_fault,
  input  logic wdog_req,
  output logic core_rst,
  output logic run_start,
  output logic osc_force,
  output logic supply_evt,
  output logic wdog_evt
);
  localparam int MAXC = (STAB_CYCLES > WD_CYCLES) ? STAB_CYCLES : WD_CYCLES;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYCLES - 1);
  localparam logic [CW-1:0] WD_LAST   = CW'(WD_CYCLES - 1);

  seq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic cnt_clr, cnt_inc;
  logic run_start_q, osc_force_q;

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      SEQ_HOLD: if (!supply_fault) begin
        st_d    = SEQ_SETTLE;
        cnt_clr = 1'b1;
      end
      SEQ_SETTLE: begin
        if (supply_fault) st_d = SEQ_HOLD;
        else if (cnt_q == STAB_LAST) st_d = SEQ_RUN;
        else cnt_inc = 1'b1;
      end
      SEQ_WDOG: begin
        if (supply_fault) st_d = SEQ_HOLD;
        else if (cnt_q == WD_LAST) st_d = SEQ_RUN;
        else cnt_inc = 1'b1;
      end
      SEQ_RUN: begin
        if (supply_fault) st_d = SEQ_HOLD;
        else if (wdog_req) begin
          st_d    = SEQ_WDOG;
          cnt_clr = 1'b1;
        end
      end
      default: st_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SEQ_HOLD;
      cnt_q       <= '0;
      run_start_q <= 1'b0;
      osc_force_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      run_start_q <= (st_d == SEQ_RUN) && (st_q != SEQ_RUN);
      osc_force_q <= supply_fault && (st_q != SEQ_HOLD);
      if (cnt_clr) cnt_q <= '0;
      else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign core_rst   = (st_q != SEQ_RUN);
  assign run_start  = run_start_q;
  assign osc_force  = osc_force_q;
  assign supply_evt = supply_fault;
  assign wdog_evt   = (st_q == SEQ_RUN) && !supply_fault && wdog_req;
endmodule

// File: rtl/pwr_cause_log.sv
module pwr_cause_log (
  input  logic clk,
  input  logic rst,
  input  logic supply_evt,
  input  logic wdog_evt,
  input  logic clr,
  output logic supply_flag,
  output logic wdog_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      supply_flag <= 1'b0;
      wdog_flag   <= 1'b0;
    end else begin
      supply_flag <= supply_evt || (supply_flag && !clr);
      wdog_flag   <= wdog_evt   || (wdog_flag   && !clr);
    end
  end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
  parameter int STAB_CYCLES = 4096,
  parameter int WD_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lv_low_i,
  input  logic bo_low_i,
  input  logic lv_off_i,
  input  logic suspend_i,
  input  logic wdog_req_i,
  input  logic cause_clr_i,
  output logic core_rst_o,
  output logic run_start_o,
  output logic osc_int_force_o,
  output logic cause_supply_o,
  output logic cause_wdog_o
);
  logic [1:0] cmp_s;
  logic supply_fault, supply_evt, wdog_evt;

  pwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i({bo_low_i, lv_low_i}), .sync_o(cmp_s)
  );

  pwr_fault_eval u_eval (
    .clk(clk), .rst(rst), .lv_s(cmp_s[0]), .bo_s(cmp_s[1]),
    .lv_off(lv_off_i), .suspend(suspend_i), .supply_fault(supply_fault)
  );

  pwr_seq_fsm #(.STAB_CYCLES(STAB_CYCLES), .WD_CYCLES(WD_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .supply_fault(supply_fault), .wdog_req(wdog_req_i),
    .core_rst(core_rst_o), .run_start(run_start_o), .osc_force(osc_int_force_o),
    .supply_evt(supply_evt), .wdog_evt(wdog_evt)
  );

  pwr_cause_log u_log (
    .clk(clk), .rst(rst), .supply_evt(supply_evt), .wdog_evt(wdog_evt),
    .clr(cause_clr_i), .supply_flag(cause_supply_o), .wdog_flag(cause_wdog_o)
  );
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk (
  input logic clk,
  input logic rst,
  input logic wdog_req_i,
  input logic cause_clr_i,
  input logic core_rst_o,
  input logic run_start_o,
  input logic osc_int_force_o,
  input logic cause_supply_o,
  input logic cause_wdog_o
);
  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    osc_int_force_o |=> !osc_int_force_o);
  // R2
  strobe_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    osc_int_force_o |-> (core_rst_o && cause_supply_o));
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    run_start_o |-> (!core_rst_o && $past(core_rst_o)));
  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    run_start_o |=> !run_start_o);
  // R10
  supply_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_supply_o && !cause_clr_i) |=> cause_supply_o);
  // R10
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_wdog_o && !cause_clr_i) |=> cause_wdog_o);
  // R9
  wdog_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!core_rst_o && wdog_req_i) |=> core_rst_o);
endmodule

bind pwr_rst_seq pwr_rst_seq_chk chk_i (
  .clk(clk), .rst(rst), .wdog_req_i(wdog_req_i), .cause_clr_i(cause_clr_i),
  .core_rst_o(core_rst_o), .run_start_o(run_start_o),
  .osc_int_force_o(osc_int_force_o), .cause_supply_o(cause_supply_o),
  .cause_wdog_o(cause_wdog_o)
);

// File: tb/pwr_rst_seq_tb_top.sv
module pwr_rst_seq_tb_top;
  localparam int STAB = 8;
  localparam int WD   = 3;
  localparam int NV   = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lv = 0, bo = 0, off = 0, sus = 0, wd = 0, clr = 0;
  logic core_rst, run_start, osc_force, c_sup, c_wd;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_rst_seq #(.STAB_CYCLES(STAB), .WD_CYCLES(WD), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .lv_low_i(lv), .bo_low_i(bo), .lv_off_i(off),
    .suspend_i(sus), .wdog_req_i(wd), .cause_clr_i(clr),
    .core_rst_o(core_rst), .run_start_o(run_start), .osc_int_force_o(osc_force),
    .cause_supply_o(c_sup), .cause_wdog_o(c_wd)
  );

  // vector: {lv,bo,off,sus,wd,clr} | edges | {core_rst,cause_supply,cause_wdog,osc_force}
  localparam logic [15:0] TBL [NV] = '{
    {6'b100000, 6'd3,  4'b1101},  // R2 low-voltage entry
    {6'b100010, 6'd1,  4'b1100},  // R9 request ignored in hold
    {6'b000000, 6'd10, 4'b1100},  // R3 one edge early
    {6'b000000, 6'd1,  4'b0100},  // R3 release
    {6'b000001, 6'd1,  4'b0000},  // R10 clear
    {6'b000010, 6'd1,  4'b1010},  // R9 watchdog entry
    {6'b000000, 6'd2,  4'b1010},  // R9 still held
    {6'b000000, 6'd1,  4'b0010},  // R9 release, no settle
    {6'b000001, 6'd1,  4'b0000},  // R10 clear
    {6'b100100, 6'd4,  4'b0000},  // R6 masked in suspend
    {6'b100000, 6'd1,  4'b1101},  // R6 active after suspend
    {6'b000000, 6'd11, 4'b0100},  // R3 release
    {6'b000010, 6'd1,  4'b1110},  // R10 supply flag kept over watchdog
    {6'b000000, 6'd3,  4'b0110},  // R9 release
    {6'b000001, 6'd1,  4'b0000},  // R10 clear
    {6'b101000, 6'd4,  4'b0000},  // R5 disabled monitor
    {6'b111000, 6'd3,  4'b1101},  // R7 brown-out with monitor off
    {6'b101000, 6'd12, 4'b1100},  // R8 re-armed monitor holds
    {6'b001000, 6'd11, 4'b0100},  // R8 release
    {6'b101000, 6'd3,  4'b1101},  // R8 still armed
    {6'b001000, 6'd11, 4'b0100},  // R8 release
    {6'b000001, 6'd1,  4'b0000},  // R10 clear, disable low
    {6'b001000, 6'd1,  4'b0000},  // R8 disable rising edge
    {6'b101000, 6'd4,  4'b0000},  // R8 re-arm removed
    {6'b111100, 6'd3,  4'b1101},  // R7 brown-out in suspend
    {6'b000000, 6'd11, 4'b0100}   // R3 release
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R2";
      1, 5, 6, 7, 13: return "R9";
      2, 3, 11, 25: return "R3";
      4, 8, 12, 14, 21: return "R10";
      9, 10: return "R6";
      15: return "R5";
      16, 24: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  initial begin
    tick(3);
    // R1 reset state
    check("R1", "core_rst in reset", core_rst, 1'b1);
    check("R1", "cause_supply in reset", c_sup, 1'b0);
    check("R1", "cause_wdog in reset", c_wd, 1'b0);
    check("R1", "osc_force in reset", osc_force, 1'b0);
    rst = 1'b0;
    tick(STAB);
    check("R1", "core_rst before release", core_rst, 1'b1);
    tick(1);
    check("R1", "core_rst released", core_rst, 1'b0);
    check("R3", "run_start at release", run_start, 1'b1);
    tick(1);
    check("R3", "run_start single", run_start, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {lv, bo, off, sus, wd, clr} = TBL[i][15:10];
      tick(int'(TBL[i][9:4]));
      check(row_tag(i), $sformatf("row %0d core_rst", i), core_rst, TBL[i][3]);
      check(row_tag(i), $sformatf("row %0d cause_supply", i), c_sup, TBL[i][2]);
      check(row_tag(i), $sformatf("row %0d cause_wdog", i), c_wd, TBL[i][1]);
      check(row_tag(i), $sformatf("row %0d osc_force", i), osc_force, TBL[i][0]);
    end

    // R4 settle count restarts
    lv = 1'b1; tick(3);
    check("R4", "fault entry", core_rst, 1'b1);
    lv = 1'b0; tick(6);
    lv = 1'b1; tick(3);
    check("R4", "back in hold", core_rst, 1'b1);
    lv = 1'b0; tick(10);
    check("R4", "full count again", core_rst, 1'b1);
    tick(1);
    check("R4", "release after full count", core_rst, 1'b0);
    check("R3", "run_start after restart", run_start, 1'b1);
    tick(1);
    check("R3", "run_start drops", run_start, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog timeout got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule